// File: doc/BRIEF.md
# Coherent 16-bit Register Read Latch

This block sits in the byte-wide read path of a register file. Some of the registers behind it are 16-bit values that the core keeps updating, such as counters and measurements. A bus that can only move one byte per access has to read such a value in two accesses. Without care, the value can change between the two accesses, and the two halves then come from different samples. To prevent this, a read of the low byte of a 16-bit register also copies that register's high byte into a single shadow byte and marks the register as frozen. When the matching high byte is read later, it comes from the shadow, and the freeze ends.

Only one register can be frozen at a time. A low-byte read of another 16-bit register moves the freeze to that register. High-byte reads of a register that is not frozen return the live value. Plain 8-bit registers and unmapped addresses are served without touching the freeze state.

Read data is registered. The byte appears on `rdData` in the cycle after the clock edge that samples `rdStrobe`, and it holds until the next strobe.

Address map:
- The 16-bit register `i` has its low byte at `WIDE_BASE + 2*i` and its high byte at `WIDE_BASE + 2*i + 1`.
- The 8-bit register `j` is at `BYTE_BASE + j`.
- Every other address reads as 00h.

Top module: `coh_rd_latch`

## Requirements
- R1: After reset, `rdData` is 00h and no register is frozen. A high-byte read therefore returns the live high byte.
- R2: A strobed read of a low-byte address (even offset from `WIDE_BASE`) returns that register's live bits [7:0] on `rdData` after the sampling edge. At the same edge, the register's live bits [15:8] are captured into the shadow.
- R3: A high-byte read (odd offset) of the frozen register returns the captured byte, even if the live value has changed since the capture.
- R4: A high-byte read of the frozen register releases the freeze. A later high-byte read of the same register returns the live byte.
- R5: A low-byte read of a different 16-bit register releases the previous freeze and freezes the new register. A high-byte read of the previous register then returns live data.
- R6: A high-byte read of a register that is not frozen returns its live high byte and leaves the current freeze in place.
- R7: A read of an 8-bit register at `BYTE_BASE + j` returns that register's value and leaves the freeze state unchanged.
- R8: A read of an address outside both regions returns 00h and leaves the freeze state unchanged.
- R9: While `rdStrobe` is low, `rdData` keeps its value, even when the live inputs change.
- R10: A repeated low-byte read of the register that is already frozen takes a fresh capture of its high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Read request, sampled on the rising edge |
| rdAddr | input | ADDR_W | Byte read address |
| wideVals | input | NUM_WIDE*16 | Live 16-bit values; register i occupies bits [16*i+15:16*i] |
| byteVals | input | NUM_BYTE*8 | Live 8-bit values; register j occupies bits [8*j+7:8*j] |
| rdData | output | 8 | Registered read data byte |

## Verification
The bench changes the live values between the low-byte read and the high-byte read. A design that did not capture the high byte would return the new live byte, and one that never released the freeze would keep returning the stale byte on the second high read.

The handover is tested from one register to another, with the old register read afterwards. Reads of the high byte of another register, of 8-bit registers and of unmapped addresses are placed between a low read and its high read. A design that let these disturb the state would lose the captured byte. The bench also reads the first address past the 16-bit region, which catches off-by-one decoding, and repeats a low-byte read to confirm that the shadow is refreshed.

// File: rtl/coh_rd_pkg.sv
package coh_rd_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO    = 2'd0,
    SEL_WIDE_LO = 2'd1,
    SEL_WIDE_HI = 2'd2,
    SEL_BYTE    = 2'd3
  } selKind_e;

  typedef struct packed {
    logic     load;       // update the output register this cycle
    logic     capture;    // copy the selected high byte into the shadow
    logic     useShadow;  // serve the high byte from the shadow
    selKind_e kind;
  } rdCtrl_t;

endpackage

// File: rtl/coh_rd_ctrl.sv
module coh_rd_ctrl
  import coh_rd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WIDE  = 4,
  parameter int NUM_BYTE  = 4,
  parameter int WIDE_BASE = 16,
  parameter int BYTE_BASE = 64,
  parameter int WIDX_W    = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1,
  parameter int BIDX_W    = (NUM_BYTE > 1) ? $clog2(NUM_BYTE) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output rdCtrl_t           ctrl,
  output logic [WIDX_W-1:0] wideIdx,
  output logic [BIDX_W-1:0] byteIdx
);

  localparam logic [ADDR_W-1:0] WIDE_START = ADDR_W'(WIDE_BASE);
  localparam logic [ADDR_W-1:0] WIDE_SPAN  = ADDR_W'(2 * NUM_WIDE);
  localparam logic [ADDR_W-1:0] BYTE_START = ADDR_W'(BYTE_BASE);
  localparam logic [ADDR_W-1:0] BYTE_SPAN  = ADDR_W'(NUM_BYTE);

  logic [ADDR_W-1:0] wideOff;
  logic [ADDR_W-1:0] byteOff;
  logic              inWide;
  logic              inByte;
  logic              isLo;
  logic              isHi;

  logic              frozenValid;
  logic [WIDX_W-1:0] frozenIdx;
  logic              hitFrozen;

  // Address decode
  always_comb begin
    wideOff = rdAddr - WIDE_START;
    byteOff = rdAddr - BYTE_START;
    inWide  = (rdAddr >= WIDE_START) && (wideOff < WIDE_SPAN);
    inByte  = (rdAddr >= BYTE_START) && (byteOff < BYTE_SPAN);
    isLo    = inWide && !wideOff[0];
    isHi    = inWide &&  wideOff[0];
    wideIdx = WIDX_W'(wideOff >> 1);
    byteIdx = BIDX_W'(byteOff);
  end

  assign hitFrozen = frozenValid && (frozenIdx == wideIdx);

  // Strobe bundle for the datapath
  always_comb begin
    ctrl.load      = rdStrobe;
    ctrl.capture   = rdStrobe && isLo;
    ctrl.useShadow = isHi && hitFrozen;
    if (isLo)        ctrl.kind = SEL_WIDE_LO;
    else if (isHi)   ctrl.kind = SEL_WIDE_HI;
    else if (inByte) ctrl.kind = SEL_BYTE;
    else             ctrl.kind = SEL_ZERO;
  end

  // Freeze ownership
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frozenValid <= 1'b0;
      frozenIdx   <= '0;
    end else if (rdStrobe && isLo) begin
      frozenValid <= 1'b1;
      frozenIdx   <= wideIdx;
    end else if (rdStrobe && isHi && hitFrozen) begin
      frozenValid <= 1'b0;
    end
  end

  // R5, R10: a low read takes ownership of the freeze
  a_r5_lo_takes_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && isLo) |=> (frozenValid && frozenIdx == $past(wideIdx)));

  // R4: a high read of the frozen register drops the freeze
  a_r4_hi_releases: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && isHi && hitFrozen) |=> !frozenValid);

  // R6, R7, R8: other reads leave the freeze state alone
  a_r7_other_reads_keep_state: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !isLo && !(isHi && hitFrozen)) |=> ($stable(frozenValid) && $stable(frozenIdx)));

  // R9: no strobe, no state change
  a_r9_idle_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ($stable(frozenValid) && $stable(frozenIdx)));

endmodule

// File: rtl/coh_rd_datapath.sv
module coh_rd_datapath
  import coh_rd_pkg::*;
#(
  parameter int NUM_WIDE = 4,
  parameter int NUM_BYTE = 4,
  parameter int WIDX_W   = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1,
  parameter int BIDX_W   = (NUM_BYTE > 1) ? $clog2(NUM_BYTE) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rdCtrl_t               ctrl,
  input  logic [WIDX_W-1:0]     wideIdx,
  input  logic [BIDX_W-1:0]     byteIdx,
  input  logic [NUM_WIDE*16-1:0] wideVals,
  input  logic [NUM_BYTE*8-1:0]  byteVals,
  output logic [7:0]            rdData
);

  logic [NUM_WIDE-1:0][15:0] wideArr;
  logic [NUM_BYTE-1:0][7:0]  byteArr;
  logic [7:0] liveLo;
  logic [7:0] liveHi;
  logic [7:0] liveByte;
  logic [7:0] shadow;
  logic [7:0] nextData;

  assign wideArr = wideVals;
  assign byteArr = byteVals;

  always_comb begin
    liveLo   = 8'h00;
    liveHi   = 8'h00;
    liveByte = 8'h00;
    if (int'(wideIdx) < NUM_WIDE) begin
      liveLo = wideArr[wideIdx][7:0];
      liveHi = wideArr[wideIdx][15:8];
    end
    if (int'(byteIdx) < NUM_BYTE) liveByte = byteArr[byteIdx];
  end

  always_comb begin
    unique case (ctrl.kind)
      SEL_WIDE_LO: nextData = liveLo;
      SEL_WIDE_HI: nextData = ctrl.useShadow ? shadow : liveHi;
      SEL_BYTE:    nextData = liveByte;
      default:     nextData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= 8'h00;
      rdData <= 8'h00;
    end else begin
      if (ctrl.capture) shadow <= liveHi;
      if (ctrl.load)    rdData <= nextData;
    end
  end

  // R2: low byte leaves with the sample that fed the shadow
  a_r2_lo_and_capture: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.kind == SEL_WIDE_LO) |=>
      (rdData == $past(liveLo) && shadow == $past(liveHi)));

  // R3: a shadowed high read returns the stored byte
  a_r3_shadow_served: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.kind == SEL_WIDE_HI && ctrl.useShadow) |=> (rdData == $past(shadow)));

  // R8: unmapped reads give zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.kind == SEL_ZERO) |=> (rdData == 8'h00));

  // R9: output holds between strobes
  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(rdData));

endmodule

// File: rtl/coh_rd_latch.sv
module coh_rd_latch
  import coh_rd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WIDE  = 4,
  parameter int NUM_BYTE  = 4,
  parameter int WIDE_BASE = 16,
  parameter int BYTE_BASE = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rdStrobe,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic [NUM_WIDE*16-1:0] wideVals,
  input  logic [NUM_BYTE*8-1:0]  byteVals,
  output logic [7:0]             rdData
);

  localparam int WIDX_W = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1;
  localparam int BIDX_W = (NUM_BYTE > 1) ? $clog2(NUM_BYTE) : 1;

  rdCtrl_t           ctrl;
  logic [WIDX_W-1:0] wideIdx;
  logic [BIDX_W-1:0] byteIdx;

  coh_rd_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WIDE(NUM_WIDE), .NUM_BYTE(NUM_BYTE),
    .WIDE_BASE(WIDE_BASE), .BYTE_BASE(BYTE_BASE),
    .WIDX_W(WIDX_W), .BIDX_W(BIDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .ctrl(ctrl), .wideIdx(wideIdx), .byteIdx(byteIdx)
  );

  coh_rd_datapath #(
    .NUM_WIDE(NUM_WIDE), .NUM_BYTE(NUM_BYTE),
    .WIDX_W(WIDX_W), .BIDX_W(BIDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .wideIdx(wideIdx), .byteIdx(byteIdx),
    .wideVals(wideVals), .byteVals(byteVals),
    .rdData(rdData)
  );

  // R1: reset leaves a zero output
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (rdData == 8'h00));

endmodule

// File: tb/coh_rd_latch_test.sv
module coh_rd_latch_test;

  localparam int NW = 4;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [NW-1:0][15:0] wide = '0;
  logic [NB-1:0][7:0]  bytes = '0;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  coh_rd_latch #(.ADDR_W(8), .NUM_WIDE(NW), .NUM_BYTE(NB),
                 .WIDE_BASE(16), .BYTE_BASE(64)) uut (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .wideVals(wide), .byteVals(bytes), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: one strobed read, expected byte goes to the scoreboard
  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdAddr   = addr;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // Monitor: data is valid after the sampling edge, compared at the next negedge
  initial begin
    forever begin
      @(posedge clk);
      if (rdStrobe && rstN) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          check("scoreboard underflow", rdData, 8'hxx);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, rdData, e);
        end
      end
    end
  end

  task automatic runAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset output", rdData, 8'h00);
    wide[0] = 16'h1234;
    rd(8'h11, 8'h12, "R1 no freeze after reset");

    wide[0] = 16'hA1B2;
    rd(8'h10, 8'hB2, "R2 low byte live");
    wide[0] = 16'hC3D4;
    rd(8'h11, 8'hA1, "R3 frozen high byte");
    rd(8'h11, 8'hC3, "R4 released after high read");

    rd(8'h10, 8'hD4, "R2 low byte reg0");
    wide[0] = 16'h5566;
    wide[1] = 16'h7788;
    rd(8'h12, 8'h88, "R5 low byte reg1");
    wide[1] = 16'h99AA;
    rd(8'h11, 8'h55, "R5 old register released");
    rd(8'h13, 8'h77, "R5 freeze moved to reg1");

    wide[2] = 16'h0102;
    rd(8'h14, 8'h02, "R2 low byte reg2");
    wide[2] = 16'h0304;
    wide[3] = 16'hEEFF;
    rd(8'h17, 8'hEE, "R6 unfrozen high is live");
    rd(8'h15, 8'h01, "R6 freeze kept");

    rd(8'h16, 8'hFF, "R2 low byte reg3");
    wide[3] = 16'h1111;
    bytes[1] = 8'h5A;
    rd(8'h41, 8'h5A, "R7 byte register value");
    rd(8'h17, 8'hEE, "R7 freeze unchanged");

    wide[1] = 16'h2468;
    rd(8'h12, 8'h68, "R2 low byte reg1 again");
    wide[1] = 16'h1357;
    rd(8'h30, 8'h00, "R8 gap address");
    rd(8'h18, 8'h00, "R8 past wide region");
    rd(8'h44, 8'h00, "R8 past byte region");
    rd(8'h0F, 8'h00, "R8 below wide region");
    rd(8'h13, 8'h24, "R8 freeze unchanged");

    rd(8'h43, 8'h00, "R7 last byte register");
    bytes[3] = 8'hC7;
    rd(8'h43, 8'hC7, "R7 byte register update");
    bytes[3] = 8'h3C;
    wide[0] = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R9 output held while idle", rdData, 8'hC7);

    wide[0] = 16'h2233;
    rd(8'h10, 8'h33, "R10 first capture");
    wide[0] = 16'h4455;
    rd(8'h10, 8'h55, "R10 second low read");
    wide[0] = 16'h6677;
    rd(8'h11, 8'h44, "R10 fresh capture");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) check("scoreboard drained", 8'(expQ.size()), 8'h00);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule